// File: doc/BRIEF.md
# Per-Word State Tag Fetch and Update Unit

This block keeps a small state tag for every aligned four-byte data word. The tags are packed into bytes inside a separate, reserved region of memory. Given a data address, the unit computes where that word's tag byte lives and fetches the byte over a simple byte-wide memory request/response port. It then either returns the word's tag or rewrites only that tag with a read-modify-write that leaves the neighbouring tags in the same byte untouched.

A caller sets a region base address and a tag width of 1, 2 or 4 bits per word, then presents one operation at a time: a read of the tag, or an update with a new tag value. All operands and configuration are captured when the request is accepted. The unit stays busy until the operation completes and signals completion with a single-cycle pulse.

The controller is a five-state machine. IDLE accepts a request and moves to READ_REQ. READ_REQ holds a byte read request until memory takes it, then moves to READ_WAIT. READ_WAIT waits for the response. For a read it completes and returns to IDLE. For an update it captures the merged byte and moves to WRITE_REQ. WRITE_REQ holds the byte write until memory takes it, then moves to WRITE_WAIT. WRITE_WAIT waits for the write acknowledge, then completes and returns to IDLE.

Top module: `stag_access`

## Requirements
- R1: The tag byte address equals `cfg_base + ((req_addr >> 2) >> (3 - L))`, where L is log2 of the tag width. The two low address bits, the byte offset inside the word, have no effect. Example: base 0xF0000000, 2-bit tags, address 0xABCD gives 0xF0000ABC.
- R2: `cfg_bits_sel` encodes the tag width as 0 = 1 bit, 1 = 2 bits, 2 = 4 bits, and 3 = 4 bits. With word index w, the tag sits at bit offset `(w mod (8 / width)) * width` of the byte.
- R3: A read issues exactly one memory request with `mem_req_we` = 0. In the cycle `mem_rsp_valid` is high, `done` pulses and `rd_state` carries the tag zero-extended to 4 bits. Example: byte 0xCA at offset 6 with a 2-bit tag gives 3.
- R4: An update first reads the tag byte. In the cycle after the read response it issues a write (`mem_req_we` = 1) to the same address. The write data is the fetched byte with only the tag field replaced by the low `width` bits of `req_new_state`. Higher bits of `req_new_state` are ignored.
- R5: An update pulses `done` in the cycle the write acknowledge (`mem_rsp_valid`) arrives, and `rd_state` then carries the tag value held before the update.
- R6: `req_ready` is high in IDLE and low from the cycle after acceptance through the `done` cycle. Requests presented while busy are ignored: no extra memory request follows.
- R7: While `mem_req_valid` is high and `mem_req_ready` is low, the valid, write flag, address and write data hold steady.
- R8: After reset `req_ready` is 1 and `mem_req_valid`, `done` and `rd_state` are 0. `rd_state` is 0 in every cycle without `done`.
- R9: Address, operation, new tag, base and width are sampled at acceptance. Changing them while busy does not change the operation in flight.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Operation request |
| req_ready | output | 1 | Unit idle and able to accept |
| req_op | input | 1 | 0 = read tag, 1 = update tag |
| req_addr | input | 32 | Data byte address |
| req_new_state | input | 4 | New tag value for update |
| cfg_base | input | 32 | Tag region base address |
| cfg_bits_sel | input | 2 | Tag width select |
| mem_req_valid | output | 1 | Memory byte request valid |
| mem_req_ready | input | 1 | Memory takes the request |
| mem_req_we | output | 1 | 1 = byte write, 0 = byte read |
| mem_req_addr | output | 32 | Tag byte address |
| mem_req_wdata | output | 8 | Byte to write |
| mem_rsp_valid | input | 1 | Read data or write acknowledge |
| mem_rsp_rdata | input | 8 | Read byte |
| done | output | 1 | Operation complete pulse |
| rd_state | output | 4 | Tag value, valid with done |

## Verification
A wrong controller state shows at the ports within one cycle. Examples are a request left asserted after its handshake, a write with no read before it, or `req_ready` rising while a response is still owed. Each of these is visible at the next negative edge after the handshake in question. A wrong captured offset or width shows as a wrong `mem_req_addr` in the first request cycle, or as a corrupted neighbour field in the write data one cycle after the read response. Disturbing the configuration inputs while busy exposes any state that is read live instead of held.

// File: rtl/stag_pkg.sv
package stag_pkg;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_READ_REQ,
        ST_READ_WAIT,
        ST_WRITE_REQ,
        ST_WRITE_WAIT
    } stag_state_e;

    typedef enum logic {
        OP_READ   = 1'b0,
        OP_UPDATE = 1'b1
    } stag_op_e;

    // Width select to log2(width): 0->0, 1->1, 2/3->2
    function automatic logic [1:0] width_log2(input logic [1:0] sel);
        return (sel == 2'd0) ? 2'd0 : (sel == 2'd1) ? 2'd1 : 2'd2;
    endfunction

endpackage

// File: rtl/stag_addr_gen.sv
module stag_addr_gen #(
    parameter int ADDR_W   = 32,
    parameter int WORD_LSB = 2
) (
    input  logic [ADDR_W-1:0] base,
    input  logic [ADDR_W-1:0] addr,
    input  logic [1:0]        lg,
    output logic [ADDR_W-1:0] byte_addr,
    output logic [2:0]        bit_off
);
    localparam int BYTE_LG = 3;

    logic [ADDR_W-1:0] word_idx;
    logic [1:0]        sh;
    logic [2:0]        slot_mask;
    logic [2:0]        slot;

    always_comb begin
        word_idx  = addr >> WORD_LSB;
        sh        = 2'(BYTE_LG - int'(lg));
        slot_mask = 3'((4'd1 << sh) - 4'd1);
        slot      = word_idx[2:0] & slot_mask;
        bit_off   = 3'(slot << lg);
        byte_addr = base + (word_idx >> sh);
    end
endmodule

// File: rtl/stag_field_unit.sv
module stag_field_unit #(
    parameter int STATE_W = 4
) (
    input  logic [7:0]         byte_in,
    input  logic [2:0]         bit_off,
    input  logic [1:0]         lg,
    input  logic [STATE_W-1:0] new_field,
    output logic [STATE_W-1:0] field_out,
    output logic [7:0]         merged
);
    localparam int BYTE_W = 8;

    logic [BYTE_W-1:0] mask;
    logic [BYTE_W-1:0] shifted;
    logic [BYTE_W-1:0] new_ext;

    always_comb begin
        mask      = BYTE_W'((9'd1 << (4'd1 << lg)) - 9'd1);
        shifted   = (byte_in >> bit_off) & mask;
        field_out = STATE_W'(shifted);
        new_ext   = BYTE_W'(new_field) & mask;
        merged    = (byte_in & ~(mask << bit_off)) | (new_ext << bit_off);
    end
endmodule

// File: rtl/stag_access.sv
module stag_access
    import stag_pkg::*;
#(
    parameter int ADDR_W   = 32,
    parameter int WORD_LSB = 2,
    parameter int STATE_W  = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic              req_op,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [STATE_W-1:0] req_new_state,
    input  logic [ADDR_W-1:0] cfg_base,
    input  logic [1:0]        cfg_bits_sel,
    output logic              mem_req_valid,
    input  logic              mem_req_ready,
    output logic              mem_req_we,
    output logic [ADDR_W-1:0] mem_req_addr,
    output logic [7:0]        mem_req_wdata,
    input  logic              mem_rsp_valid,
    input  logic [7:0]        mem_rsp_rdata,
    output logic              done,
    output logic [STATE_W-1:0] rd_state
);

    stag_state_e st_q, st_d;

    logic [1:0]         in_lg;
    logic [ADDR_W-1:0]  in_byte_addr;
    logic [2:0]         in_off;

    stag_op_e           op_q;
    logic [ADDR_W-1:0]  byte_addr_q;
    logic [2:0]         off_q;
    logic [1:0]         lg_q;
    logic [STATE_W-1:0] new_q;
    logic [7:0]         merged_q;
    logic [STATE_W-1:0] old_q;

    logic [STATE_W-1:0] rsp_field;
    logic [7:0]         rsp_merged;

    logic               accept;
    logic               rd_rsp;

    assign in_lg = width_log2(cfg_bits_sel);

    stag_addr_gen #(
        .ADDR_W  (ADDR_W),
        .WORD_LSB(WORD_LSB)
    ) u_addr (
        .base     (cfg_base),
        .addr     (req_addr),
        .lg       (in_lg),
        .byte_addr(in_byte_addr),
        .bit_off  (in_off)
    );

    stag_field_unit #(
        .STATE_W(STATE_W)
    ) u_field (
        .byte_in  (mem_rsp_rdata),
        .bit_off  (off_q),
        .lg       (lg_q),
        .new_field(new_q),
        .field_out(rsp_field),
        .merged   (rsp_merged)
    );

    assign accept = (st_q == ST_IDLE) && req_valid;
    assign rd_rsp = (st_q == ST_READ_WAIT) && mem_rsp_valid;

    // State register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= ST_IDLE;
        end else begin
            st_q <= st_d;
        end
    end

    // Operand capture
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            op_q        <= OP_READ;
            byte_addr_q <= '0;
            off_q       <= '0;
            lg_q        <= '0;
            new_q       <= '0;
            merged_q    <= '0;
            old_q       <= '0;
        end else begin
            if (accept) begin
                op_q        <= stag_op_e'(req_op);
                byte_addr_q <= in_byte_addr;
                off_q       <= in_off;
                lg_q        <= in_lg;
                new_q       <= req_new_state;
            end
            if (rd_rsp) begin
                merged_q <= rsp_merged;
                old_q    <= rsp_field;
            end
        end
    end

    // Next state
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE:       if (req_valid)     st_d = ST_READ_REQ;
            ST_READ_REQ:   if (mem_req_ready) st_d = ST_READ_WAIT;
            ST_READ_WAIT:  if (mem_rsp_valid)
                               st_d = (op_q == OP_UPDATE) ? ST_WRITE_REQ : ST_IDLE;
            ST_WRITE_REQ:  if (mem_req_ready) st_d = ST_WRITE_WAIT;
            ST_WRITE_WAIT: if (mem_rsp_valid) st_d = ST_IDLE;
            default:                          st_d = ST_IDLE;
        endcase
    end

    // Outputs
    always_comb begin
        req_ready     = 1'b0;
        mem_req_valid = 1'b0;
        mem_req_we    = 1'b0;
        mem_req_addr  = byte_addr_q;
        mem_req_wdata = '0;
        done          = 1'b0;
        rd_state      = '0;
        unique case (st_q)
            ST_IDLE: req_ready = 1'b1;
            ST_READ_REQ: mem_req_valid = 1'b1;
            ST_READ_WAIT: begin
                if (mem_rsp_valid && op_q == OP_READ) begin
                    done     = 1'b1;
                    rd_state = rsp_field;
                end
            end
            ST_WRITE_REQ: begin
                mem_req_valid = 1'b1;
                mem_req_we    = 1'b1;
                mem_req_wdata = merged_q;
            end
            ST_WRITE_WAIT: begin
                if (mem_rsp_valid) begin
                    done     = 1'b1;
                    rd_state = old_q;
                end
            end
            default: ;
        endcase
    end

endmodule

// File: rtl/stag_access_chk.sv
module stag_access_chk #(
    parameter int ADDR_W  = 32,
    parameter int STATE_W = 4
) (
    input logic               clk,
    input logic               rst_n,
    input logic               req_ready,
    input logic               mem_req_valid,
    input logic               mem_req_ready,
    input logic               mem_req_we,
    input logic [ADDR_W-1:0]  mem_req_addr,
    input logic [7:0]         mem_req_wdata,
    input logic               mem_rsp_valid,
    input logic               done,
    input logic [STATE_W-1:0] rd_state
);
    logic [ADDR_W-1:0] last_rd_addr_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            last_rd_addr_q <= '0;
        end else if (mem_req_valid && !mem_req_we && mem_req_ready) begin
            last_rd_addr_q <= mem_req_addr;
        end
    end

    a_r6_busy_not_ready: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !req_ready);

    a_r6_ready_after_done: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> req_ready);

    a_r7_request_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=> (mem_req_valid && $stable(mem_req_addr)
            && $stable(mem_req_we) && $stable(mem_req_wdata)));

    a_r3_done_with_rsp: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> mem_rsp_valid);

    a_r8_state_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !done |-> (rd_state == '0));

    a_r4_write_follows_read: assert property (@(posedge clk) disable iff (!rst_n)
        ($rose(mem_req_valid) && mem_req_we) |-> $past(mem_rsp_valid));

    a_r4_write_same_addr: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_we) |-> (mem_req_addr == last_rd_addr_q));

endmodule

bind stag_access stag_access_chk #(
    .ADDR_W (ADDR_W),
    .STATE_W(STATE_W)
) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .req_ready    (req_ready),
    .mem_req_valid(mem_req_valid),
    .mem_req_ready(mem_req_ready),
    .mem_req_we   (mem_req_we),
    .mem_req_addr (mem_req_addr),
    .mem_req_wdata(mem_req_wdata),
    .mem_rsp_valid(mem_rsp_valid),
    .done         (done),
    .rd_state     (rd_state)
);

// File: tb/stag_access_tb.sv
`timescale 1ns/1ps
module stag_access_tb;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic        req_op = 1'b0;
    logic [31:0] req_addr = '0;
    logic [3:0]  req_new_state = '0;
    logic [31:0] cfg_base = '0;
    logic [1:0]  cfg_bits_sel = '0;
    logic        mem_req_valid;
    logic        mem_req_ready = 1'b0;
    logic        mem_req_we;
    logic [31:0] mem_req_addr;
    logic [7:0]  mem_req_wdata;
    logic        mem_rsp_valid = 1'b0;
    logic [7:0]  mem_rsp_rdata = '0;
    logic        done;
    logic [3:0]  rd_state;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #5 clk = ~clk;

    stag_access u_dut (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_op(req_op),
        .req_addr(req_addr), .req_new_state(req_new_state),
        .cfg_base(cfg_base), .cfg_bits_sel(cfg_bits_sel),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_we(mem_req_we), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata), .done(done), .rd_state(rd_state)
    );

    task automatic check(input bit ok, input string req, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s: actual 0x%0h expected 0x%0h", req, what, act, exp);
        end
    endtask

    // Generic operation driver with a bench-side memory model
    task automatic run_op(input bit op, input logic [31:0] addr, input logic [3:0] nst,
                          input logic [31:0] base, input logic [1:0] sel,
                          input logic [7:0] rbyte, input logic [31:0] exp_addr,
                          input logic [3:0] exp_field, input logic [7:0] exp_wdata,
                          input int rdy_dly, input int rsp_dly, input bit disturb,
                          input string req);
        @(negedge clk);
        req_valid = 1'b1; req_op = op; req_addr = addr; req_new_state = nst;
        cfg_base = base; cfg_bits_sel = sel;
        check(req_ready == 1'b1, "R6", "ready in idle", 32'(req_ready), 1);
        @(negedge clk);
        req_valid = 1'b0;
        if (disturb) begin
            req_valid = 1'b1; req_op = ~op; req_addr = ~addr;
            req_new_state = ~nst; cfg_base = ~base; cfg_bits_sel = sel + 2'd1;
        end
        check(mem_req_valid && !mem_req_we, req, "read request", {mem_req_valid, mem_req_we}, 2'b10);
        check(mem_req_addr == exp_addr, req, "read address", mem_req_addr, exp_addr);
        check(req_ready == 1'b0, "R6", "busy", 32'(req_ready), 0);
        for (int i = 0; i < rdy_dly; i++) begin
            @(negedge clk);
            check(mem_req_valid && mem_req_addr == exp_addr, "R7", "held read addr", mem_req_addr, exp_addr);
        end
        mem_req_ready = 1'b1;
        @(negedge clk);
        mem_req_ready = 1'b0;
        check(mem_req_valid == 1'b0, "R3", "single read request", 32'(mem_req_valid), 0);
        for (int i = 0; i < rsp_dly; i++) begin
            @(negedge clk);
            check(done == 1'b0, "R3", "no early done", 32'(done), 0);
        end
        mem_rsp_valid = 1'b1; mem_rsp_rdata = rbyte;
        #1;
        if (!op) begin
            check(done == 1'b1, "R3", "done on read response", 32'(done), 1);
            check(rd_state == exp_field, req, "read tag", 32'(rd_state), 32'(exp_field));
            @(negedge clk);
            mem_rsp_valid = 1'b0;
        end else begin
            check(done == 1'b0, "R5", "no done on read phase", 32'(done), 0);
            @(negedge clk);
            mem_rsp_valid = 1'b0;
            check(mem_req_valid && mem_req_we, "R4", "write request", {mem_req_valid, mem_req_we}, 2'b11);
            check(mem_req_addr == exp_addr, "R4", "write address", mem_req_addr, exp_addr);
            check(mem_req_wdata == exp_wdata, req, "write data", 32'(mem_req_wdata), 32'(exp_wdata));
            for (int i = 0; i < rdy_dly; i++) begin
                @(negedge clk);
                check(mem_req_valid && mem_req_wdata == exp_wdata, "R7", "held write data", 32'(mem_req_wdata), 32'(exp_wdata));
            end
            mem_req_ready = 1'b1;
            @(negedge clk);
            mem_req_ready = 1'b0;
            for (int i = 0; i < rsp_dly; i++) begin
                @(negedge clk);
                check(done == 1'b0, "R5", "no early done", 32'(done), 0);
            end
            mem_rsp_valid = 1'b1; mem_rsp_rdata = 8'h00;
            #1;
            check(done == 1'b1, "R5", "done on write ack", 32'(done), 1);
            check(rd_state == exp_field, "R5", "old tag on update", 32'(rd_state), 32'(exp_field));
            @(negedge clk);
            mem_rsp_valid = 1'b0;
        end
        req_valid = 1'b0;
        check(req_ready == 1'b1, "R6", "ready after done", 32'(req_ready), 1);
        check(rd_state == 4'd0 && done == 1'b0, "R8", "quiet after done", 32'(rd_state), 0);
        @(negedge clk);
        check(mem_req_valid == 1'b0, "R6", "busy request ignored", 32'(mem_req_valid), 0);
    endtask

    task automatic t_reset();
        check(req_ready == 1'b1, "R8", "reset ready", 32'(req_ready), 1);
        check(mem_req_valid == 1'b0, "R8", "reset mem valid", 32'(mem_req_valid), 0);
        check(done == 1'b0 && rd_state == 4'd0, "R8", "reset done/state", 32'(rd_state), 0);
    endtask

    // R1 R2 R3: worked example, 2-bit tags
    task automatic t_read_example();
        run_op(1'b0, 32'h0000_ABCD, 4'h0, 32'hF000_0000, 2'd1, 8'hCA,
               32'hF000_0ABC, 4'h3, 8'h00, 0, 0, 1'b0, "R1");
    endtask

    // R2 R3: 1-bit tags, top slot, with memory stalls
    task automatic t_read_one_bit();
        run_op(1'b0, 32'h1000_001C, 4'h0, 32'h2000_0000, 2'd0, 8'h80,
               32'h2080_0000, 4'h1, 8'h00, 2, 3, 1'b0, "R2");
    endtask

    // R1: byte offset inside the word ignored, 4-bit tags
    task automatic t_read_four_bit();
        run_op(1'b0, 32'h0000_0044, 4'h0, 32'h0000_1000, 2'd2, 8'h5A,
               32'h0000_1008, 4'h5, 8'h00, 0, 1, 1'b0, "R2");
        run_op(1'b0, 32'h0000_0047, 4'h0, 32'h0000_1000, 2'd2, 8'h5A,
               32'h0000_1008, 4'h5, 8'h00, 1, 0, 1'b0, "R1");
    endtask

    // R2: select 3 behaves as 4-bit tags; R6 R9 busy disturbance
    task automatic t_read_sel3_disturb();
        run_op(1'b0, 32'h0000_0040, 4'h0, 32'h0000_1000, 2'd3, 8'h5A,
               32'h0000_1008, 4'hA, 8'h00, 1, 1, 1'b1, "R9");
    endtask

    // R4 R5 R9: 2-bit update, upper new bits ignored, inputs disturbed
    task automatic t_update_two_bit();
        run_op(1'b1, 32'h0000_0000, 4'h6, 32'h3000_0000, 2'd1, 8'hFF,
               32'h3000_0000, 4'h3, 8'hFE, 1, 2, 1'b1, "R4");
    endtask

    // R4: 1-bit update at slot 5
    task automatic t_update_one_bit();
        run_op(1'b1, 32'h0000_0014, 4'h1, 32'h0000_0200, 2'd0, 8'h00,
               32'h0000_0200, 4'h0, 8'h20, 0, 0, 1'b0, "R4");
    endtask

    // R4 R5: 4-bit update of the high nibble
    task automatic t_update_four_bit();
        run_op(1'b1, 32'h0000_0004, 4'hA, 32'h0000_0300, 2'd2, 8'h3C,
               32'h0000_0300, 4'h3, 8'hAC, 2, 1, 1'b0, "R5");
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_read_example();
        t_read_one_bit();
        t_read_four_bit();
        t_read_sel3_disturb();
        t_update_two_bit();
        t_update_one_bit();
        t_update_four_bit();
        finished = 1'b1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!finished) begin
            n_checks++;
            n_fail++;
            $display("FAIL watchdog: actual hung expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    end

endmodule